// File: doc/BRIEF.md
# Counter-Flow Systolic Vector-Matrix Multiplier

This block computes the row-vector product Y = X × A for an N × N signed matrix, with N = 4 by default. It is a line of 2N−1 identical inner-product cells with one register per cell. Operands x travel from the left end of the line to the right, one cell per clock edge. Partial sums y travel from the right end to the left, also one cell per edge. Each x item and each y item leaves an empty slot behind it, so every x item meets every y item in exactly one cell. At that meeting the cell adds the product of x and the matrix element offered on its side port.

The user places x_i on the x input and the starting value of y_j on the y input on alternate edges. The user also offers each matrix element to the one cell and the one edge where its x and y meet, so the elements enter the line as diagonal bands. The completed sums leave the left end in index order, each one flagged by a one-cycle valid strobe.

Top module: `vmx_systolic_top`

## Requirements
- R1: The line has 2N−1 cells. A y value sampled on `y_init` at edge e is presented on `y_out`, with `y_out_valid` high, right after edge e+2N−2. Along the way it is unchanged wherever no multiply takes place.
- R2: A cell adds x·a to the passing y only when the x, y and a items it sees on the same edge are all valid. If any one of the three is missing, y passes through unchanged, so a withheld matrix element counts as zero.
- R3: x values move left to right unchanged, one cell per edge. An x sampled on `x_in` at edge e is at cell k's multiplier at edge e+k. Cell 0 is the cell where x enters and y leaves.
- R4: Edges are counted from the edge that samples x_0, which is edge 0. x_i is sampled at edge 2i and the start value of y_j at edge 2j. Element a_ij (row i, column j) must be valid at cell k = N−1+j−i at edge i+j+N−1. Slice k of `a_in` is bits [16k+15:16k]. Neither stream may be valid on two consecutive edges.
- R5: y_j = yinit_j + Σ_i x_i·a_ij, computed exactly in 40-bit two's complement, with x, a signed 16-bit. This includes all operands at −32768.
- R6: `y_out_valid` is high for exactly one cycle per result, in the order y_0, y_1, …, spaced two cycles apart, and low in every other cycle.
- R7: A synchronous active-high reset clears every cell's valid bits and data, so `y_out` and `y_out_valid` read 0 afterwards.
- R8: Matrix values flagged valid on a cell at an edge where x and y are not both present there have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 16 | Signed x operand entering cell 0 |
| x_in_valid | input | 1 | x_in holds an item |
| y_init | input | 40 | Signed start value of a sum, entering cell 2N−2 |
| y_init_valid | input | 1 | y_init holds an item |
| a_in | input | 16·(2N−1) | Signed matrix element for each cell, 16-bit slice per cell |
| a_valid | input | 2N−1 | Per-cell matrix element present |
| y_out | output | 40 | Signed completed sum leaving cell 0 |
| y_out_valid | output | 1 | y_out holds a completed sum |

## Verification
The checks take for granted that x and y items never arrive on back-to-back edges, since the one-result-per-two-cycles output spacing relies on it. They also take for granted that a matrix element valid at a meeting slot belongs to that slot. The stimulus drives both streams only on even edges and derives each element's cell and edge from the R4 formula. Every other cell-edge slot is either left idle or, in the R8 runs, filled with random values flagged valid. A full drain interval separates successive operations, so no items from one product meet items from the next.

// File: rtl/vmx_pkg.sv
`timescale 1ns/1ps
package vmx_pkg;

    localparam int VMX_N_DEFAULT      = 4;
    localparam int VMX_DATA_W_DEFAULT = 16;
    localparam int VMX_ACC_W_DEFAULT  = 40;

    // number of cells needed for an n x n counter-flow product
    function automatic int vmx_cell_count(input int n);
        return 2 * n - 1;
    endfunction

endpackage

// File: rtl/vmx_ipcell.sv
`timescale 1ns/1ps
module vmx_ipcell #(
    parameter int DATA_W = vmx_pkg::VMX_DATA_W_DEFAULT,
    parameter int ACC_W  = vmx_pkg::VMX_ACC_W_DEFAULT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     x_vld_i,
    input  logic signed [DATA_W-1:0] x_dat_i,
    input  logic                     y_vld_i,
    input  logic signed [ACC_W-1:0]  y_dat_i,
    input  logic                     a_vld_i,
    input  logic signed [DATA_W-1:0] a_dat_i,
    output logic                     x_vld_o,
    output logic signed [DATA_W-1:0] x_dat_o,
    output logic                     y_vld_o,
    output logic signed [ACC_W-1:0]  y_dat_o
);

    typedef struct packed {
        logic                     vld;
        logic signed [ACC_W-1:0]  dat;
    } ytok_t;

    typedef struct packed {
        logic                     vld;
        logic signed [DATA_W-1:0] dat;
    } xtok_t;

    logic                       fire;
    logic signed [2*DATA_W-1:0] prod;
    logic signed [ACC_W-1:0]    prod_ext;
    ytok_t                      y_next, y_q;
    xtok_t                      x_q;

    always_comb begin
        fire     = x_vld_i & y_vld_i & a_vld_i;
        prod     = x_dat_i * a_dat_i;
        prod_ext = ACC_W'(prod);
        y_next.vld = y_vld_i;
        y_next.dat = fire ? (y_dat_i + prod_ext) : y_dat_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            x_q.vld <= x_vld_i;
            x_q.dat <= x_dat_i;
            y_q     <= y_next;
        end
    end

    assign x_vld_o = x_q.vld;
    assign x_dat_o = x_q.dat;
    assign y_vld_o = y_q.vld;
    assign y_dat_o = y_q.dat;

endmodule

// File: rtl/vmx_systolic_top.sv
`timescale 1ns/1ps
module vmx_systolic_top #(
    parameter int N      = vmx_pkg::VMX_N_DEFAULT,
    parameter int DATA_W = vmx_pkg::VMX_DATA_W_DEFAULT,
    parameter int ACC_W  = vmx_pkg::VMX_ACC_W_DEFAULT
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DATA_W-1:0]           x_in,
    input  logic                        x_in_valid,
    input  logic [ACC_W-1:0]            y_init,
    input  logic                        y_init_valid,
    input  logic [(2*N-1)*DATA_W-1:0]   a_in,
    input  logic [2*N-2:0]              a_valid,
    output logic [ACC_W-1:0]            y_out,
    output logic                        y_out_valid
);

    localparam int NCELL = vmx_pkg::vmx_cell_count(N);
    localparam int LAST  = NCELL - 1;

    // registered state of each cell
    logic                     xv_q [NCELL];
    logic signed [DATA_W-1:0] xd_q [NCELL];
    logic                     yv_q [NCELL];
    logic signed [ACC_W-1:0]  yd_q [NCELL];

    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        logic                     xv_in;
        logic signed [DATA_W-1:0] xd_in;
        logic                     yv_in;
        logic signed [ACC_W-1:0]  yd_in;

        if (k == 0) begin : g_xedge
            assign xv_in = x_in_valid;
            assign xd_in = $signed(x_in);
        end else begin : g_xlink
            assign xv_in = xv_q[k-1];
            assign xd_in = xd_q[k-1];
        end

        if (k == LAST) begin : g_yedge
            assign yv_in = y_init_valid;
            assign yd_in = $signed(y_init);
        end else begin : g_ylink
            assign yv_in = yv_q[k+1];
            assign yd_in = yd_q[k+1];
        end

        vmx_ipcell #(
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W)
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .x_vld_i (xv_in),
            .x_dat_i (xd_in),
            .y_vld_i (yv_in),
            .y_dat_i (yd_in),
            .a_vld_i (a_valid[k]),
            .a_dat_i ($signed(a_in[k*DATA_W +: DATA_W])),
            .x_vld_o (xv_q[k]),
            .x_dat_o (xd_q[k]),
            .y_vld_o (yv_q[k]),
            .y_dat_o (yd_q[k])
        );
    end

    assign y_out       = yd_q[0];
    assign y_out_valid = yv_q[0];

endmodule

// File: rtl/vmx_checker.sv
`timescale 1ns/1ps
module vmx_checker #(
    parameter int N      = 4,
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     x_in_valid,
    input logic [DATA_W-1:0]        x_in,
    input logic                     y_init_valid,
    input logic [2*N-2:0]           a_valid,
    input logic                     y_out_valid,
    input logic                     xv_q [2*N-1],
    input logic signed [DATA_W-1:0] xd_q [2*N-1],
    input logic                     yv_q [2*N-1],
    input logic signed [ACC_W-1:0]  yd_q [2*N-1]
);

    localparam int NC = 2 * N - 1;

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R7: one edge after reset was seen, the output is quiet
    always @(posedge clk) begin
        if (rst_q) begin
            a_r7_reset_clears: assert (!y_out_valid);
        end
    end

    // R4: input streams keep an empty slot between items
    a_r4_x_gap: assert property (@(posedge clk) disable iff (rst)
        x_in_valid |=> !x_in_valid);
    a_r4_y_gap: assert property (@(posedge clk) disable iff (rst)
        y_init_valid |=> !y_init_valid);

    // R6: results never arrive on back-to-back cycles
    a_r6_out_gap: assert property (@(posedge clk) disable iff (rst)
        y_out_valid |=> !y_out_valid);

    // R3: cell 0 captures the x port unchanged
    a_r3_x_entry: assert property (@(posedge clk) disable iff (rst)
        x_in_valid |=> (xv_q[0] && xd_q[0] == $past($signed(x_in))));

    for (genvar k = 1; k < NC; k++) begin : g_xchk
        // R3: x moves one cell right per edge, unchanged
        a_r3_x_travel: assert property (@(posedge clk) disable iff (rst)
            xv_q[k-1] |=> (xv_q[k] && xd_q[k] == $past(xd_q[k-1])));
    end

    for (genvar k = 0; k < NC - 1; k++) begin : g_ychk
        logic xv_seen;
        if (k == 0) begin : g_e
            assign xv_seen = x_in_valid;
        end else begin : g_l
            assign xv_seen = xv_q[k-1];
        end

        // R1: y valid moves one cell left per edge
        a_r1_y_travel: assert property (@(posedge clk) disable iff (rst)
            yv_q[k+1] |=> yv_q[k]);

        // R2: without a full operand set the sum passes unchanged
        a_r2_y_hold: assert property (@(posedge clk) disable iff (rst)
            (yv_q[k+1] && !(xv_seen && a_valid[k])) |=> (yd_q[k] == $past(yd_q[k+1])));
    end

endmodule

bind vmx_systolic_top vmx_checker #(
    .N      (N),
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W)
) u_vmx_checker (
    .clk          (clk),
    .rst          (rst),
    .x_in_valid   (x_in_valid),
    .x_in         (x_in),
    .y_init_valid (y_init_valid),
    .a_valid      (a_valid),
    .y_out_valid  (y_out_valid),
    .xv_q         (xv_q),
    .xd_q         (xd_q),
    .yv_q         (yv_q),
    .yd_q         (yd_q)
);

// File: tb/tb_vmx_systolic_top.sv
`timescale 1ns/1ps
module tb_vmx_systolic_top;

    localparam int N  = 4;
    localparam int NC = 2 * N - 1;
    localparam int DW = 16;
    localparam int AW = 40;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DW-1:0]     x_in = '0;
    logic              x_in_valid = 1'b0;
    logic [AW-1:0]     y_init = '0;
    logic              y_init_valid = 1'b0;
    logic [NC*DW-1:0]  a_in = '0;
    logic [NC-1:0]     a_valid = '0;
    logic [AW-1:0]     y_out;
    logic              y_out_valid;

    int     n_run  = 0;
    int     n_fail = 0;
    bit     finished = 0;

    int     xs [N];
    int     am [N][N];
    longint yi [N];
    bit     drop [N][N];
    bit     junk;

    always #2 clk = ~clk;   // 250 MHz

    vmx_systolic_top #(.N(N), .DATA_W(DW), .ACC_W(AW)) dut (
        .clk          (clk),
        .rst          (rst),
        .x_in         (x_in),
        .x_in_valid   (x_in_valid),
        .y_init       (y_init),
        .y_init_valid (y_init_valid),
        .a_in         (a_in),
        .a_valid      (a_valid),
        .y_out        (y_out),
        .y_out_valid  (y_out_valid)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int rnd16();
        return int'($signed(16'($urandom)));
    endfunction

    function automatic longint rnd_init();
        return longint'($signed(32'($urandom))) * 37;
    endfunction

    task automatic clear_op();
        for (int i = 0; i < N; i++) begin
            xs[i] = 0;
            yi[i] = 0;
            for (int j = 0; j < N; j++) begin
                am[i][j]   = 0;
                drop[i][j] = 1'b0;
            end
        end
        junk = 1'b0;
    endtask

    // drives one full product and checks every output cycle
    task automatic run_op(input string tag);
        longint expv [N];
        for (int j = 0; j < N; j++) begin
            expv[j] = yi[j];
            for (int i = 0; i < N; i++)
                if (!drop[i][j]) expv[j] += longint'(xs[i]) * longint'(am[i][j]);
        end
        for (int t = 0; t <= 4 * N; t++) begin
            @(negedge clk);
            if (t >= 1) begin
                int r;
                bit ev;
                r  = t - 1 - (2 * N - 2);
                ev = (r >= 0) && (r % 2 == 0) && (r / 2 < N);
                chk(y_out_valid == ev, "R6", longint'(y_out_valid), longint'(ev));
                if (ev)
                    chk(longint'($signed(y_out)) == expv[r/2], tag,
                        longint'($signed(y_out)), expv[r/2]);
            end
            // inputs for edge t
            x_in_valid   = (t % 2 == 0) && (t / 2 < N);
            x_in         = x_in_valid ? DW'(xs[t/2]) : '0;
            y_init_valid = x_in_valid;
            y_init       = y_init_valid ? AW'(yi[t/2]) : '0;
            for (int k = 0; k < NC; k++) begin
                int ii, jj;
                bit meet;
                ii   = (t - k) / 2;
                jj   = (t + k - 2 * N + 2) / 2;
                meet = ((t - k) % 2 == 0) && (t >= k) && (ii < N) &&
                       (t + k - 2 * N + 2 >= 0) && (jj < N);
                if (meet) begin
                    a_valid[k]            = !drop[ii][jj];
                    a_in[k*DW +: DW]      = DW'(am[ii][jj]);
                end else begin
                    a_valid[k]            = junk;
                    a_in[k*DW +: DW]      = junk ? DW'($urandom) : '0;
                end
            end
        end
        @(negedge clk);
        x_in_valid = 1'b0; y_init_valid = 1'b0; a_valid = '0; a_in = '0;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_fail++;
            $display("FAIL R6: watchdog expired, actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(y_out_valid == 1'b0, "R7", longint'(y_out_valid), 0);
        chk(y_out == '0, "R7", longint'(y_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(y_out_valid == 1'b0, "R7", longint'(y_out_valid), 0);

        // R1: every element withheld, start values come out untouched
        clear_op();
        for (int i = 0; i < N; i++) begin
            xs[i] = rnd16();
            yi[i] = rnd_init();
            for (int j = 0; j < N; j++) begin
                am[i][j]   = rnd16();
                drop[i][j] = 1'b1;
            end
        end
        run_op("R1");

        // R3: sweep a single non-zero element over every position
        for (int si = 0; si < N; si++) begin
            for (int sj = 0; sj < N; sj++) begin
                clear_op();
                for (int i = 0; i < N; i++) xs[i] = 100 * (i + 1) + 7;
                am[si][sj] = -(si * N + sj + 3);
                run_op("R3");
            end
        end

        // R4: identity matrix returns x in index order
        clear_op();
        for (int i = 0; i < N; i++) begin
            xs[i] = 1000 - 333 * i;
            am[i][i] = 1;
        end
        run_op("R4");

        // R5: extreme operands and large start values
        clear_op();
        for (int i = 0; i < N; i++) begin
            xs[i] = -32768;
            yi[i] = 64'sd100000000000;
            for (int j = 0; j < N; j++) am[i][j] = -32768;
        end
        run_op("R5");
        clear_op();
        for (int i = 0; i < N; i++) begin
            xs[i] = 32767;
            yi[i] = -64'sd200000000000;
            for (int j = 0; j < N; j++) am[i][j] = -32768;
        end
        run_op("R5");

        // R5: random matrices and vectors
        for (int n = 0; n < 30; n++) begin
            clear_op();
            for (int i = 0; i < N; i++) begin
                xs[i] = rnd16();
                yi[i] = (n % 2 == 0) ? 0 : rnd_init();
                for (int j = 0; j < N; j++) am[i][j] = rnd16();
            end
            run_op("R5");
        end

        // R8: random values flagged valid on every non-meeting slot
        for (int n = 0; n < 10; n++) begin
            clear_op();
            junk = 1'b1;
            for (int i = 0; i < N; i++) begin
                xs[i] = rnd16();
                yi[i] = rnd_init();
                for (int j = 0; j < N; j++) am[i][j] = rnd16();
            end
            run_op("R8");
        end

        // R2: random elements withheld at their meeting slot
        for (int n = 0; n < 10; n++) begin
            clear_op();
            for (int i = 0; i < N; i++) begin
                xs[i] = rnd16();
                yi[i] = rnd_init();
                for (int j = 0; j < N; j++) begin
                    am[i][j]   = rnd16();
                    drop[i][j] = 1'($urandom);
                end
            end
            run_op("R2");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule